// File: doc/BRIEF.md
# Software Command Sequence Detector

This block sits beside a byte-wide SRAM and watches the accesses made to it. A host asks for a nonvolatile operation without any command register. It reads six fixed addresses in a strict order. The first five addresses are the same for both commands, and the sixth address picks the operation. When the sixth read completes, the block raises a one-clock STORE or RECALL request for the nonvolatile controller.

Each completed access is marked by a one-cycle strobe, `acc_done`. The strobe is sampled together with the address, the active-low chip enable, the write enable and the output enable. While the final read of a sequence is in progress, the block tells the data pads to float. During every other read, the pads drive data whenever the output enable is low. Only the lower fourteen address bits are compared, and the output enable has no say in detection.

Top module: `sw_cmd_detect`

## Requirements
- R1: After reset the matcher is idle: both request outputs are 0, and a lone read of 0x0FC0 or 0x0C63 raises no request.
- R2: Reads of 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0, on consecutive strobed accesses, raise `store_req` for exactly the clock after the sixth strobe.
- R3: The same five reads followed by a read of 0x0C63 raise `recall_req` for exactly the clock after the sixth strobe.
- R4: Address bit 14 is ignored. A sequence with bit 14 set on any of its accesses still triggers.
- R5: A read whose address is not the next one expected resets the matcher. If that address is 0x0E38, it counts as step one of a new sequence.
- R6: A strobed write (`ce_n`=0, `we_n`=0) resets the matcher and never raises a request, whatever its address.
- R7: A sixth read of 0x339C raises neither request and resets the matcher.
- R8: The level of `oe_n` has no effect on matching or on the requests.
- R9: `dq_hiz` is 1 exactly when the current access is a read (`ce_n`=0, `we_n`=1), five steps are matched, and the low address bits are 0x0FC0 or 0x0C63. `dq_drive` is 1 for a read with `oe_n`=0 and `dq_hiz`=0, and is 0 otherwise.
- R10: A strobe with `ce_n`=1 is not an access. It leaves the matcher unchanged and raises no request.
- R11: Each request lasts one clock, and `store_req` and `recall_req` are never high together. A second sequence may follow immediately after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 15 | Address of the current access |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| acc_done | input | 1 | One-cycle strobe marking a completed access |
| store_req | output | 1 | One-clock STORE request |
| recall_req | output | 1 | One-clock RECALL request |
| dq_hiz | output | 1 | Data pads float during the final read of a sequence |
| dq_drive | output | 1 | Data pads drive read data |

## Verification
The detector is run through these patterns:
- Clean STORE and RECALL runs, which show that the last address alone picks the operation.
- The same runs with bit 14 set, and with the output enable held high, which show that neither input takes part in matching.
- Broken runs: a stray address, a restart on 0x0E38 in the middle of a sequence, a write in the middle, and a reserved 0x339C ending. These separate the restart-at-step-one behaviour from a plain return to idle.
- A deselected strobe inside a sequence, which checks that a non-access does not count as a break.
- Back-to-back commands, which confirm that each request is a single clock.

The pad flags are checked on every access of these runs.

// File: rtl/sw_cmd_detect.sv
module sw_cmd_detect #(
  parameter int ADDR_W = 15,
  parameter int KEY_W  = 14,
  parameter logic [KEY_W-1:0] KEY0       = 'h0E38,
  parameter logic [KEY_W-1:0] KEY1       = 'h31C7,
  parameter logic [KEY_W-1:0] KEY2       = 'h03E0,
  parameter logic [KEY_W-1:0] KEY3       = 'h3C1F,
  parameter logic [KEY_W-1:0] KEY4       = 'h303F,
  parameter logic [KEY_W-1:0] KEY_STORE  = 'h0FC0,
  parameter logic [KEY_W-1:0] KEY_RECALL = 'h0C63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              acc_done,
  output logic              store_req,
  output logic              recall_req,
  output logic              dq_hiz,
  output logic              dq_drive
);
  localparam int PREFIX = 5;
  localparam int STEP_W = $clog2(PREFIX + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(PREFIX);

  logic [STEP_W-1:0] step;
  logic [KEY_W-1:0]  key, want;
  logic              rd, wr, at_last, hit_next, hit_store, hit_recall;
  logic              unused_hi;

  assign key       = addr[KEY_W-1:0];
  assign unused_hi = ^addr[ADDR_W-1:KEY_W];
  assign rd        = !ce_n && we_n;
  assign wr        = !ce_n && !we_n;
  assign at_last   = (step == LAST);

  always_comb begin
    case (step)
      STEP_W'(0): want = KEY0;
      STEP_W'(1): want = KEY1;
      STEP_W'(2): want = KEY2;
      STEP_W'(3): want = KEY3;
      STEP_W'(4): want = KEY4;
      default:    want = KEY0;
    endcase
  end

  assign hit_next   = !at_last && (key == want);
  assign hit_store  = at_last && (key == KEY_STORE);
  assign hit_recall = at_last && (key == KEY_RECALL);

  assign dq_hiz   = rd && (hit_store || hit_recall);
  assign dq_drive = rd && !oe_n && !dq_hiz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step       <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= acc_done && rd && hit_store;
      recall_req <= acc_done && rd && hit_recall;
      if (acc_done && !ce_n) begin
        if (wr)
          step <= '0;
        else if (hit_next)
          step <= step + 1'b1;
        else if (key == KEY0)
          step <= STEP_W'(1);
        else
          step <= '0;
      end
    end
  end
endmodule

// File: rtl/sw_cmd_detect_chk.sv
module sw_cmd_detect_chk #(
  parameter int ADDR_W = 15,
  parameter int KEY_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              we_n,
  input logic              acc_done,
  input logic              store_req,
  input logic              recall_req,
  input logic              dq_hiz,
  input logic              dq_drive
);
  logic [KEY_W-1:0] k;
  logic             unused_hi;
  assign k         = addr[KEY_W-1:0];
  assign unused_hi = ^addr[ADDR_W-1:KEY_W];

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));
  assert_store_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);
  assert_recall_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);
  assert_store_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> $past(acc_done && !ce_n && we_n && k == KEY_W'('h0FC0)));
  assert_recall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> $past(acc_done && !ce_n && we_n && k == KEY_W'('h0C63)));
  assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !ce_n && !we_n) |=> !(store_req || recall_req));
  assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && k == KEY_W'('h339C)) |=> !(store_req || recall_req));
  assert_desel_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && ce_n) |=> !(store_req || recall_req));
  assert_hiz_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_hiz |-> (!ce_n && we_n && !dq_drive));
endmodule

bind sw_cmd_detect sw_cmd_detect_chk #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
  .acc_done(acc_done), .store_req(store_req), .recall_req(recall_req),
  .dq_hiz(dq_hiz), .dq_drive(dq_drive)
);

// File: tb/sw_cmd_detect_tb.sv
`timescale 1ns/1ps
module sw_cmd_detect_tb;
  logic        clk = 0, rst_n = 0;
  logic [14:0] addr = '0;
  logic        ce_n = 1, we_n = 1, oe_n = 1, acc_done = 0;
  logic        store_req, recall_req, dq_hiz, dq_drive;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { bit st; bit rc; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  sw_cmd_detect u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .acc_done(acc_done), .store_req(store_req),
    .recall_req(recall_req), .dq_hiz(dq_hiz), .dq_drive(dq_drive)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit strobe;
    strobe = acc_done;
    #1;
    if (rst_n && strobe) begin
      exp_t e;
      if (q.size() == 0) check(0, "R11", "queue empty", 1, 0);
      else begin
        e = q.pop_front();
        check(store_req == e.st, e.tag, "store_req", store_req, e.st);
        check(recall_req == e.rc, e.tag, "recall_req", recall_req, e.rc);
      end
    end else if (rst_n && (store_req || recall_req)) begin
      check(0, "R11", "pulse without strobe", {store_req, recall_req}, 0);
    end
  end

  task automatic acc(input logic [14:0] a, input bit e, input bit w, input bit g,
                     input bit st, input bit rc, input bit hz, input string tag);
    @(negedge clk);
    addr = a; ce_n = e; we_n = w; oe_n = g; acc_done = 1;
    q.push_back('{st: st, rc: rc, tag: tag});
    #0.5;
    check(dq_hiz == hz, "R9", {"dq_hiz ", tag}, dq_hiz, hz);
    check(dq_drive == (!e && w && !g && !hz), "R9", {"dq_drive ", tag},
          dq_drive, (!e && w && !g && !hz));
  endtask

  task automatic rd(input logic [14:0] a, input bit st, input bit rc,
                    input bit hz, input string tag);
    acc(a, 0, 1, 0, st, rc, hz, tag);
  endtask

  task automatic prefix(input logic [14:0] hi, input bit g, input string tag);
    acc(15'h0E38 | hi, 0, 1, g, 0, 0, 0, tag);
    acc(15'h31C7 | hi, 0, 1, g, 0, 0, 0, tag);
    acc(15'h03E0 | hi, 0, 1, g, 0, 0, 0, tag);
    acc(15'h3C1F | hi, 0, 1, g, 0, 0, 0, tag);
    acc(15'h303F | hi, 0, 1, g, 0, 0, 0, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    acc_done = 0; ce_n = 1; we_n = 1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      check(0, "R1", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(store_req == 0 && recall_req == 0, "R1", "reset outputs",
          {store_req, recall_req}, 0);
    rst_n = 1;
    rd(15'h0FC0, 0, 0, 0, "R1");
    rd(15'h0C63, 0, 0, 0, "R1");
    idle();

    prefix(15'h0, 0, "R2");
    rd(15'h0FC0, 1, 0, 1, "R2");
    idle();

    prefix(15'h0, 0, "R3");
    rd(15'h0C63, 0, 1, 1, "R3");
    idle();

    prefix(15'h4000, 0, "R4");
    rd(15'h4FC0, 1, 0, 1, "R4");
    idle();

    rd(15'h0E38, 0, 0, 0, "R5");
    rd(15'h31C7, 0, 0, 0, "R5");
    rd(15'h1234, 0, 0, 0, "R5");
    rd(15'h03E0, 0, 0, 0, "R5");
    rd(15'h3C1F, 0, 0, 0, "R5");
    rd(15'h303F, 0, 0, 0, "R5");
    rd(15'h0FC0, 0, 0, 0, "R5");
    rd(15'h0E38, 0, 0, 0, "R5");
    rd(15'h31C7, 0, 0, 0, "R5");
    rd(15'h03E0, 0, 0, 0, "R5");
    rd(15'h0E38, 0, 0, 0, "R5");
    rd(15'h31C7, 0, 0, 0, "R5");
    rd(15'h03E0, 0, 0, 0, "R5");
    rd(15'h3C1F, 0, 0, 0, "R5");
    rd(15'h303F, 0, 0, 0, "R5");
    rd(15'h0FC0, 1, 0, 1, "R5");
    idle();

    prefix(15'h0, 0, "R6");
    acc(15'h0FC0, 0, 0, 0, 0, 0, 0, "R6");
    rd(15'h0FC0, 0, 0, 0, "R6");
    prefix(15'h0, 0, "R6");
    acc(15'h0C63, 0, 0, 1, 0, 0, 0, "R6");
    idle();

    prefix(15'h0, 0, "R7");
    rd(15'h339C, 0, 0, 0, "R7");
    rd(15'h0FC0, 0, 0, 0, "R7");
    idle();

    prefix(15'h0, 1, "R8");
    acc(15'h0C63, 0, 1, 1, 0, 1, 1, "R8");
    idle();

    prefix(15'h0, 0, "R10");
    acc(15'h1234, 1, 1, 0, 0, 0, 0, "R10");
    acc(15'h0FC0, 1, 1, 0, 0, 0, 0, "R10");
    rd(15'h0FC0, 1, 0, 1, "R10");
    idle();

    prefix(15'h0, 0, "R9");
    rd(15'h2222, 0, 0, 0, "R9");
    idle();

    prefix(15'h0, 0, "R11");
    rd(15'h0FC0, 1, 0, 1, "R11");
    prefix(15'h0, 0, "R11");
    rd(15'h0C63, 0, 1, 1, "R11");
    idle();

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R11", "leftover expectations", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule